// File: doc/BRIEF.md
# Composable-Control 16-bit ALU

This block is a purely combinational arithmetic logic unit with two 16-bit operands and six single-bit controls. Each operand first goes through its own conditioning path. That path can force the operand to zero and can then invert it bit by bit. A function stage then either adds the two conditioned operands in two's complement or ANDs them bit by bit. A last stage can invert the function result. Two flags report whether the final result is zero and whether it is negative.

Eighteen control settings give a useful set of functions: constants, copies, negations, increments, decrements, sums, differences, AND and OR. These come from the fixed order of the stages rather than from an opcode decoder. Every other control setting still yields whatever the same datapath computes. A caller drives the operands and controls and reads the result in the same cycle. The block holds no state.

Top module: `ctl_alu16`

## Requirements
- R1: When `zero_x` is 1, operand x enters the datapath as 0. When it is 0, x passes unchanged.
- R2: When `inv_x` is 1, the x operand is inverted bit by bit after the zeroing step, so `zero_x`=1 with `inv_x`=1 gives all ones (-1).
- R3: `zero_y` and `inv_y` act on operand y in the same order and with the same effect that R1 and R2 describe for x.
- R4: When `sel_add` is 1, the function stage outputs the sum of the conditioned operands modulo 2^16. Any carry out of bit 15 is discarded.
- R5: When `sel_add` is 0, the function stage outputs the bitwise AND of the conditioned operands.
- R6: When `inv_out` is 1, `result` is the bitwise inverse of the function-stage output. Otherwise it equals that output.
- R7: `is_zero` is 1 exactly when all 16 bits of `result` are 0.
- R8: `is_neg` is 1 exactly when bit 15 of `result` is 1.
- R9: The control word {zero_x,inv_x,zero_y,inv_y,sel_add,inv_out} selects these functions: 101010=0, 111111=1, 111010=-1, 001100=x, 110000=y, 001101=~x, 110001=~y, 001111=-x, 110011=-y, 011111=x+1, 110111=y+1, 001110=x-1, 110010=y-1, 000010=x+y, 010011=x-y, 000111=y-x, 000000=x&y, 010101=x|y.
- R10: The 46 control words not listed in R9 produce the result of the same stage sequence, with no special casing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| zero_x | input | 1 | Force x to zero |
| inv_x | input | 1 | Invert x after zeroing |
| zero_y | input | 1 | Force y to zero |
| inv_y | input | 1 | Invert y after zeroing |
| sel_add | input | 1 | 1 selects add, 0 selects AND |
| inv_out | input | 1 | Invert the function output |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Result bit 15 is set |

## Verification
The block contains no register, so `result`, `is_zero` and `is_neg` all respond to a stimulus in the same cycle it is applied, once the carry has rippled through the 16 bits. The bench drives operands and controls at a clock edge and samples all three outputs half a clock period later, before the next stimulus. This means every value it reads belongs to the current input. The expected value for each of the eighteen named functions is computed arithmetically from that function's meaning. The unnamed control words are checked against a stage-order model.

// File: rtl/ctl_alu16_pkg.sv
// Package: shared types for the composable-control ALU.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package ctl_alu16_pkg;
    // Conditioning controls for one operand, applied zero first then invert.
    typedef struct packed {
        logic zero;
        logic inv;
    } opnd_ctl_t;

    // Function-stage controls.
    typedef struct packed {
        logic sel_add;
        logic inv_out;
    } func_ctl_t;
endpackage

// File: rtl/alu_opnd_cond.sv
// Module: operand conditioner. Forces the operand to zero, then optionally
// inverts it bit by bit; the order is fixed so zero+invert yields all ones.
// Assumes: W >= 1; purely combinational.
module alu_opnd_cond
    import ctl_alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_in,
    input  opnd_ctl_t    ctl,
    output logic [W-1:0] opnd_out
);
    logic [W-1:0] zeroed;

    // Zeroing step followed by the inversion step.
    always_comb begin
        zeroed   = ctl.zero ? '0 : opnd_in;
        opnd_out = ctl.inv ? ~zeroed : zeroed;
    end
endmodule

// File: rtl/alu_ripple_add.sv
// Module: W-bit ripple-carry adder built from a chain of full-adder cells.
// The carry out of the top bit is not formed, so the sum wraps modulo 2^W.
// Assumes: W >= 2; purely combinational.
module alu_ripple_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        // Sum bit of full-adder cell i.
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            // Carry into the next cell; the top cell's carry is dropped.
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/alu_func_stage.sv
// Module: function and output stage. Selects add or AND of the conditioned
// operands, optionally inverts the result, and forms the zero/negative flags.
// Assumes: W >= 2; purely combinational.
module alu_func_stage
    import ctl_alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  func_ctl_t    ctl,
    output logic [W-1:0] res,
    output logic         flag_zero,
    output logic         flag_neg
);
    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] picked;

    alu_ripple_add #(.W(W)) i_add (
        .a   (a),
        .b   (b),
        .sum (sum)
    );

    // Pick the function, apply output inversion, derive the flags.
    always_comb begin
        picked    = ctl.sel_add ? sum : (a & b);
        res       = ctl.inv_out ? ~picked : picked;
        flag_zero = (res == '0);
        flag_neg  = res[MSB];
    end
endmodule

// File: rtl/ctl_alu16.sv
// Module: top of the composable-control ALU. Two operand conditioners feed a
// function stage; the six controls compose the whole function set.
// Assumes: purely combinational, no clock or reset.
module ctl_alu16
    import ctl_alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         zero_x,
    input  logic         inv_x,
    input  logic         zero_y,
    input  logic         inv_y,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] result,
    output logic         is_zero,
    output logic         is_neg
);
    logic [W-1:0] x_cond;
    logic [W-1:0] y_cond;
    opnd_ctl_t    x_ctl;
    opnd_ctl_t    y_ctl;
    func_ctl_t    f_ctl;

    // Pack the loose control pins into stage control structs.
    always_comb begin
        x_ctl = '{zero: zero_x, inv: inv_x};
        y_ctl = '{zero: zero_y, inv: inv_y};
        f_ctl = '{sel_add: sel_add, inv_out: inv_out};
    end

    alu_opnd_cond #(.W(W)) i_cond_x (
        .opnd_in  (x_in),
        .ctl      (x_ctl),
        .opnd_out (x_cond)
    );

    alu_opnd_cond #(.W(W)) i_cond_y (
        .opnd_in  (y_in),
        .ctl      (y_ctl),
        .opnd_out (y_cond)
    );

    alu_func_stage #(.W(W)) i_func (
        .a         (x_cond),
        .b         (y_cond),
        .ctl       (f_ctl),
        .res       (result),
        .flag_zero (is_zero),
        .flag_neg  (is_neg)
    );
endmodule

// File: rtl/ctl_alu16_chk.sv
// Module: assertion checker for ctl_alu16, attached by bind. Relates the
// top-level ports to each other; immediate assertions since the block is
// combinational.
module ctl_alu16_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] x_in,
    input logic [W-1:0] y_in,
    input logic         zero_x,
    input logic         inv_x,
    input logic         zero_y,
    input logic         inv_y,
    input logic         sel_add,
    input logic         inv_out,
    input logic [W-1:0] result,
    input logic         is_zero,
    input logic         is_neg
);
    logic [W-1:0] fn_out;

    // Recover the function-stage output from the result port.
    always_comb fn_out = inv_out ? ~result : result;

    // Port-level relations between controls, operands and outputs.
    always_comb begin
        assert_zero_flag_R7: assert (is_zero == (result == '0))
            else $error("is_zero disagrees with result");
        assert_neg_flag_R8: assert (is_neg == result[W-1])
            else $error("is_neg disagrees with result sign bit");
        if (zero_x && inv_x && zero_y && inv_y && !sel_add)
            assert_all_ones_and_R2: assert (fn_out == '1)
                else $error("zeroed and inverted operands did not AND to all ones");
        if (zero_x && !inv_x && !sel_add)
            assert_zero_x_and_R1: assert (fn_out == '0)
                else $error("zeroed x did not clear AND output");
        if (!zero_x && !inv_x && zero_y && !inv_y && sel_add)
            assert_add_identity_R4: assert (fn_out == x_in)
                else $error("x plus zero did not give x");
        if (zero_x && !inv_x && !zero_y && !inv_y && sel_add)
            assert_add_y_identity_R3: assert (fn_out == y_in)
                else $error("zero plus y did not give y");
        if (!zero_x && !inv_x && !zero_y && !inv_y && !sel_add)
            assert_and_R5: assert (fn_out == (x_in & y_in))
                else $error("AND of raw operands wrong");
    end
endmodule

bind ctl_alu16 ctl_alu16_chk #(.W(W)) i_ctl_alu16_chk (
    .x_in    (x_in),
    .y_in    (y_in),
    .zero_x  (zero_x),
    .inv_x   (inv_x),
    .zero_y  (zero_y),
    .inv_y   (inv_y),
    .sel_add (sel_add),
    .inv_out (inv_out),
    .result  (result),
    .is_zero (is_zero),
    .is_neg  (is_neg)
);

// File: tb/test_ctl_alu16.sv
module test_ctl_alu16;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic [W-1:0] x_in, y_in;
    logic         zero_x, inv_x, zero_y, inv_y, sel_add, inv_out;
    logic [W-1:0] result;
    logic         is_zero, is_neg;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctl_alu16 #(.W(W)) i_ctl_alu16 (
        .x_in (x_in), .y_in (y_in),
        .zero_x (zero_x), .inv_x (inv_x), .zero_y (zero_y), .inv_y (inv_y),
        .sel_add (sel_add), .inv_out (inv_out),
        .result (result), .is_zero (is_zero), .is_neg (is_neg)
    );

    // Control words of the named functions, bit 5 = zero_x ... bit 0 = inv_out (R9).
    logic [5:0] fn_code [18] = '{6'b101010, 6'b111111, 6'b111010, 6'b001100,
        6'b110000, 6'b001101, 6'b110001, 6'b001111, 6'b110011, 6'b011111,
        6'b110111, 6'b001110, 6'b110010, 6'b000010, 6'b010011, 6'b000111,
        6'b000000, 6'b010101};

    // Arithmetic meaning of each named function.
    function automatic logic [W-1:0] fn_expect(int k, logic [W-1:0] x, logic [W-1:0] y);
        case (k)
            0:  return 16'd0;
            1:  return 16'd1;
            2:  return 16'hFFFF;
            3:  return x;
            4:  return y;
            5:  return ~x;
            6:  return ~y;
            7:  return 16'd0 - x;
            8:  return 16'd0 - y;
            9:  return x + 16'd1;
            10: return y + 16'd1;
            11: return x - 16'd1;
            12: return y - 16'd1;
            13: return x + y;
            14: return x - y;
            15: return y - x;
            16: return x & y;
            default: return x | y;
        endcase
    endfunction

    // Stage-order model for arbitrary control words (R10).
    function automatic logic [W-1:0] stage_expect(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
        logic [W-1:0] a, b, f;
        a = c[5] ? '0 : x;
        a = c[4] ? ~a : a;
        b = c[3] ? '0 : y;
        b = c[2] ? ~b : b;
        f = c[1] ? a + b : a & b;
        return c[0] ? ~f : f;
    endfunction

    task automatic apply(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
        @(posedge clk);
        {zero_x, inv_x, zero_y, inv_y, sel_add, inv_out} = c;
        x_in = x;
        y_in = y;
        #(CLK_PERIOD / 2);
    endtask

    task automatic check(string req, logic [W-1:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s result=%h expected=%h", req, result, exp);
        end
        checks++;
        if (is_zero !== (exp == '0)) begin
            errors++;
            $display("FAIL R7 is_zero=%b expected=%b", is_zero, exp == '0);
        end
        checks++;
        if (is_neg !== exp[W-1]) begin
            errors++;
            $display("FAIL R8 is_neg=%b expected=%b", is_neg, exp[W-1]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired result=%h expected=done", result);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] corner [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
        void'($urandom(32'd1234));
        // Idle state: all controls low, operands zero gives AND = 0.
        apply(6'b000000, 16'h0000, 16'h0000);
        check("R5 idle", 16'h0000);
        // R1: zero_x alone, AND with y gives 0; with add gives y.
        apply(6'b100000, 16'hBEEF, 16'hFFFF);
        check("R1 zero_x and", 16'h0000);
        // R2: zero then invert x is all ones; AND passes y.
        apply(6'b110000, 16'h1234, 16'hA5A5);
        check("R2 zero-inv x", 16'hA5A5);
        // R3: zero then invert y, AND passes x.
        apply(6'b001100, 16'h5A5A, 16'h4321);
        check("R3 zero-inv y", 16'h5A5A);
        // R4: carry out of bit 15 discarded.
        apply(6'b000010, 16'hFFFF, 16'h0001);
        check("R4 wrap", 16'h0000);
        apply(6'b000010, 16'h8000, 16'h8000);
        check("R4 wrap msb", 16'h0000);
        // R6: inverted AND.
        apply(6'b000001, 16'hF0F0, 16'hFF00);
        check("R6 nand", 16'h0FFF);
        // R9: all named functions over corner operands.
        for (int k = 0; k < 18; k++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) begin
                    apply(fn_code[k], corner[i], corner[j]);
                    check("R9 corner", fn_expect(k, corner[i], corner[j]));
                end
        // R9: named functions over random operands.
        for (int n = 0; n < 150; n++)
            for (int k = 0; k < 18; k++) begin
                logic [W-1:0] rx, ry;
                rx = W'($urandom);
                ry = W'($urandom);
                apply(fn_code[k], rx, ry);
                check("R9 random", fn_expect(k, rx, ry));
            end
        // R10: every control word, random operands.
        for (int n = 0; n < 10; n++)
            for (int c = 0; c < 64; c++) begin
                logic [W-1:0] rx, ry;
                rx = W'($urandom);
                ry = W'($urandom);
                apply(6'(c), rx, ry);
                check("R10 any word", stage_expect(6'(c), rx, ry));
            end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule